// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

A 32-bit processor core that completes one instruction in every clock cycle. It recognises register add and subtract, OR with a zero-extended immediate, word load, word store, branch-if-equal and an absolute jump. The core holds the program counter, a 32-entry register file, the immediate extender, a three-function ALU and a hardwired decoder. Every control point is derived from the opcode field and, for register-format words, the function field.

Instruction memory and data memory sit outside the core. The instruction port puts out the current PC and takes the instruction word back in the same cycle. The data port puts out an address, store data and a write strobe, and takes the read word back combinationally. Register and data-memory writes take effect on the rising edge that ends the instruction's cycle. The reset is asynchronous and active-low.

Top module: `sc_core`

## Requirements
- R1: While reset is held the instruction address is 0 and no data-memory write is requested; the first instruction after release is fetched from address 0.
- R2: Register-format words (opcode 000000) with funct 100000 write rs+rt into rd, and with funct 100010 write rs-rt into rd (bits: op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0]).
- R3: Opcode 001101 writes rs OR zero-extended imm16[15:0] into rt.
- R4: Opcode 100011 loads the word at rs+sign-extended imm16 into rt; opcode 101011 stores rt at rs+sign-extended imm16.
- R5: Opcode 000100 compares rs with rt; if equal the next PC is PC+4+(sign-extended imm16 shifted left by 2), otherwise PC+4.
- R6: Opcode 000010 sets the next PC to {PC[31:28], target[25:0], 2'b00}.
- R7: Register 0 always reads as zero; writes to it are discarded.
- R8: Any other opcode, or any other funct under opcode 000000, writes nothing and advances the PC by 4.
- R9: Only the store asserts the data-memory write strobe; store, branch and jump never write the register file.
- R10: A register written by one instruction holds the new value for the very next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Current PC, byte address of the instruction |
| imem_data_i | input | 32 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 32 | Data-memory byte address (ALU result) |
| dmem_wdata_o | output | 32 | Store data (register rt) |
| dmem_we_o | output | 1 | Data-memory write strobe, taken on the rising edge |
| dmem_rdata_i | input | 32 | Word read at dmem_addr_o, same cycle |

## Verification
Every result is due one edge after its instruction is presented. A register write is visible to the instruction fetched next. The data address, store data and write strobe are valid combinationally in the instruction's own cycle, and the new PC shows on the instruction address after a single rising edge. The bench releases reset on a falling edge and advances by whole cycles. It samples the PC and the data strobe on the falling edge after the k-th rising edge, where instruction k is due. It reads back register contents only through stores into its own memory model once the program has run.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    wr_rd;     // destination is rd, else rt
    logic    b_imm;     // ALU operand B is the extended immediate
    logic    ext_sign;  // sign-extend imm16
    logic    ld_sel;    // write-back from data memory
    logic    reg_we;
    logic    mem_we;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_core_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (op_i)
      OP_RTYPE: begin
        if (funct_i == FN_ADD) begin
          ctrl_o.wr_rd  = 1'b1;
          ctrl_o.reg_we = 1'b1;
        end else if (funct_i == FN_SUB) begin
          ctrl_o.wr_rd  = 1'b1;
          ctrl_o.reg_we = 1'b1;
          ctrl_o.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.alu_op = ALU_OR;
      end
      OP_LW: begin
        ctrl_o.b_imm    = 1'b1;
        ctrl_o.ext_sign = 1'b1;
        ctrl_o.ld_sel   = 1'b1;
        ctrl_o.reg_we   = 1'b1;
      end
      OP_SW: begin
        ctrl_o.b_imm    = 1'b1;
        ctrl_o.ext_sign = 1'b1;
        ctrl_o.mem_we   = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_J: begin
        ctrl_o.jump = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  output logic [XLEN-1:0] da_o,
  output logic [XLEN-1:0] db_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);

  logic [XLEN-1:0] regs [NREGS];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs[i] <= '0;
      else if (we_i && (wa_i == AW'(i)))          regs[i] <= wd_i;
    end
  end

  assign da_o = regs[ra_i];
  assign db_o = regs[rb_i];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_fetch.sv
module sc_fetch #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            branch_i,
  input  logic            zero_i,
  input  logic            jump_i,
  input  logic [XLEN-1:0] imm_ext_i,
  input  logic [25:0]     target_i,
  output logic [XLEN-1:0] pc_o
);

  logic [XLEN-1:0] pc_q, pc_inc, pc_br, pc_jmp, pc_d;

  assign pc_inc = pc_q + XLEN'(4);
  assign pc_br  = pc_inc + {imm_ext_i[XLEN-3:0], 2'b00};
  assign pc_jmp = {pc_q[XLEN-1:28], target_i, 2'b00};

  always_comb begin
    if (jump_i)                   pc_d = pc_jmp;
    else if (branch_i && zero_i)  pc_d = pc_br;
    else                          pc_d = pc_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);

  ctrl_t           ctrl;
  logic [AW-1:0]   rs_addr, rt_addr, rd_addr, wr_addr;
  logic [XLEN-1:0] rs_data, rt_data, imm_ext, alu_b, alu_y, wr_data;
  logic            alu_zero;

  assign rs_addr = imem_data_i[21 +: AW];
  assign rt_addr = imem_data_i[16 +: AW];
  assign rd_addr = imem_data_i[11 +: AW];

  sc_decoder u_dec (
    .op_i    (imem_data_i[31:26]),
    .funct_i (imem_data_i[5:0]),
    .ctrl_o  (ctrl)
  );

  assign imm_ext = {{(XLEN-16){ctrl.ext_sign & imem_data_i[15]}}, imem_data_i[15:0]};
  assign alu_b   = ctrl.b_imm ? imm_ext : rt_data;
  assign wr_addr = ctrl.wr_rd ? rd_addr : rt_addr;
  assign wr_data = ctrl.ld_sel ? dmem_rdata_i : alu_y;

  sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (rs_addr),
    .rb_i   (rt_addr),
    .da_o   (rs_data),
    .db_o   (rt_data),
    .we_i   (ctrl.reg_we),
    .wa_i   (wr_addr),
    .wd_i   (wr_data)
  );

  sc_alu #(.XLEN(XLEN)) u_alu (
    .op_i   (ctrl.alu_op),
    .a_i    (rs_data),
    .b_i    (alu_b),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // branch offset always sign-extended, independent of ext_sign
  logic [XLEN-1:0] br_off;
  assign br_off = {{(XLEN-16){imem_data_i[15]}}, imem_data_i[15:0]};

  sc_fetch #(.XLEN(XLEN)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .branch_i  (ctrl.branch),
    .zero_i    (alu_zero),
    .jump_i    (ctrl.jump),
    .imm_ext_i (br_off),
    .target_i  (imem_data_i[25:0]),
    .pc_o      (imem_addr_o)
  );

  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_data;
  assign dmem_we_o    = ctrl.mem_we & rst_ni;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] imem_addr_o,
  input logic [31:0] imem_data_i,
  input logic [31:0] dmem_addr_o,
  input logic [31:0] dmem_wdata_o,
  input logic        dmem_we_o,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i
);

  logic [5:0]  op;
  logic [31:0] sx;
  assign op = imem_data_i[31:26];
  assign sx = {{16{imem_data_i[15]}}, imem_data_i[15:0]};

  // R4
  store_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'b101011) |-> (dmem_addr_o == rs_val_i + sx) && (dmem_wdata_o == rt_val_i));

  // R5
  branch_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'b000100) && (rs_val_i == rt_val_i)
      |=> imem_addr_o == $past(imem_addr_o) + 32'd4 + {$past(sx[29:0]), 2'b00});

  // R6
  jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'b000010)
      |=> imem_addr_o == {$past(imem_addr_o[31:28]), $past(imem_data_i[25:0]), 2'b00});

  // R8
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 6'b000010) && !((op == 6'b000100) && (rs_val_i == rt_val_i))
      |=> imem_addr_o == $past(imem_addr_o) + 32'd4);

  // R9
  store_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (op == 6'b101011));

  // R7
  r0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_data_i[25:21] == 5'd0) |-> (rs_val_i == 32'd0));

  // R5
  pc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_addr_o[1:0] == 2'b00);

endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .imem_addr_o  (imem_addr_o),
  .imem_data_i  (imem_data_i),
  .dmem_addr_o  (dmem_addr_o),
  .dmem_wdata_o (dmem_wdata_o),
  .dmem_we_o    (dmem_we_o),
  .rs_val_i     (rs_data),
  .rt_val_i     (rt_data)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] imem_addr_o, imem_data_i;
  logic [31:0] dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        dmem_we_o;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sc_core u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr_o),
    .imem_data_i  (imem_data_i),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_wdata_o (dmem_wdata_o),
    .dmem_we_o    (dmem_we_o),
    .dmem_rdata_i (dmem_rdata_i)
  );

  assign imem_data_i  = imem[imem_addr_o[9:2]];
  assign dmem_rdata_i = dmem[dmem_addr_o[9:2]];

  always @(posedge clk_i) if (dmem_we_o) dmem[dmem_addr_o[9:2]] <= dmem_wdata_o;

  localparam logic [5:0] OP_ORI = 6'b001101, OP_LW = 6'b100011, OP_SW = 6'b101011,
                         OP_BEQ = 6'b000100;

  function automatic logic [31:0] r_op(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                       logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] i_op(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                       logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] j_op(logic [25:0] t);
    return {6'b000010, t};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected <= %0d", cyc, WDOG_LIMIT);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      imem[i] = 32'd0;
      dmem[i] = 32'd0;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    clear_mem();
    imem[0] = i_op(OP_SW, 5'd0, 5'd0, 16'h0000);
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 pc in reset", imem_addr_o, 32'd0);
    chk("R1 no store in reset", {31'd0, dmem_we_o}, 32'd0);
    rst_ni = 1'b1;
    #1;
    chk("R1 first fetch", imem_addr_o, 32'd0);
  endtask

  task automatic t_arith();
    clear_mem();
    imem[0] = i_op(OP_ORI, 5'd0, 5'd1, 16'h0005);
    imem[1] = i_op(OP_ORI, 5'd0, 5'd2, 16'h0003);
    imem[2] = r_op(5'd1, 5'd2, 5'd3, 6'b100000);
    imem[3] = r_op(5'd2, 5'd1, 5'd4, 6'b100010);
    imem[4] = i_op(OP_SW, 5'd0, 5'd3, 16'h0000);
    imem[5] = i_op(OP_SW, 5'd0, 5'd4, 16'h0004);
    imem[6] = i_op(OP_ORI, 5'd0, 5'd5, 16'hFFFF);
    imem[7] = i_op(OP_SW, 5'd0, 5'd5, 16'h0008);
    do_reset();
    run(8);
    chk("R2 R10 add", dmem[0], 32'd8);
    chk("R2 sub negative", dmem[1], 32'hFFFF_FFFE);
    chk("R3 ori zero-extend", dmem[2], 32'h0000_FFFF);
  endtask

  task automatic t_mem();
    clear_mem();
    dmem[4] = 32'hDEAD_BEEF;
    imem[0] = i_op(OP_ORI, 5'd0, 5'd1, 16'd20);
    imem[1] = i_op(OP_LW,  5'd1, 5'd2, 16'hFFFC);
    imem[2] = i_op(OP_SW,  5'd1, 5'd2, 16'hFFF8);
    imem[3] = i_op(OP_ORI, 5'd0, 5'd5, 16'd4);
    imem[4] = i_op(OP_SW,  5'd5, 5'd5, 16'd4);
    imem[5] = i_op(OP_SW,  5'd0, 5'd5, 16'd0);
    do_reset();
    run(2);
    chk("R4 store strobe", {31'd0, dmem_we_o}, 32'd1);
    chk("R4 store address", dmem_addr_o, 32'd12);
    run(4);
    chk("R4 load then store", dmem[3], 32'hDEAD_BEEF);
    chk("R4 store offset", dmem[2], 32'd4);
    chk("R9 store leaves rt", dmem[0], 32'd4);
  endtask

  task automatic t_r0();
    clear_mem();
    dmem[0] = 32'hFFFF_FFFF;
    dmem[1] = 32'hFFFF_FFFF;
    imem[0] = i_op(OP_ORI, 5'd0, 5'd0, 16'h1234);
    imem[1] = i_op(OP_ORI, 5'd0, 5'd1, 16'h0007);
    imem[2] = r_op(5'd1, 5'd1, 5'd0, 6'b100000);
    imem[3] = i_op(OP_SW, 5'd0, 5'd0, 16'd0);
    imem[4] = i_op(OP_SW, 5'd0, 5'd1, 16'd4);
    do_reset();
    run(5);
    chk("R7 r0 stays zero", dmem[0], 32'd0);
    chk("R7 r0 source reads zero", dmem[1], 32'd7);
  endtask

  task automatic t_branch();
    clear_mem();
    imem[0] = i_op(OP_ORI, 5'd0, 5'd1, 16'd1);
    imem[1] = i_op(OP_ORI, 5'd0, 5'd2, 16'd1);
    imem[2] = i_op(OP_BEQ, 5'd1, 5'd2, 16'd2);
    imem[3] = i_op(OP_ORI, 5'd0, 5'd3, 16'h0BAD);
    imem[4] = i_op(OP_SW,  5'd0, 5'd3, 16'd0);
    imem[5] = i_op(OP_BEQ, 5'd1, 5'd0, 16'd5);
    imem[6] = i_op(OP_BEQ, 5'd0, 5'd0, 16'hFFFF);
    do_reset();
    run(3);
    chk("R5 taken forward", imem_addr_o, 32'd20);
    run(1);
    chk("R5 not taken", imem_addr_o, 32'd24);
    run(1);
    chk("R5 taken backward", imem_addr_o, 32'd24);
    chk("R9 branch no store", {31'd0, dmem_we_o}, 32'd0);
  endtask

  task automatic t_jump();
    clear_mem();
    imem[0]  = j_op(26'h10);
    imem[1]  = i_op(OP_ORI, 5'd0, 5'd1, 16'h0099);
    imem[2]  = i_op(OP_BEQ, 5'd0, 5'd0, 16'hFFFF);
    imem[16] = i_op(OP_ORI, 5'd0, 5'd1, 16'd3);
    imem[17] = i_op(OP_SW,  5'd0, 5'd1, 16'd0);
    imem[18] = j_op(26'd2);
    do_reset();
    run(1);
    chk("R6 jump forward", imem_addr_o, 32'h40);
    run(3);
    chk("R6 jump back", imem_addr_o, 32'h08);
    chk("R6 skipped word not run", dmem[0], 32'd3);
  endtask

  task automatic t_illegal();
    clear_mem();
    imem[0] = i_op(OP_ORI, 5'd0, 5'd1, 16'd9);
    imem[1] = {6'b111111, 5'd0, 5'd1, 16'h0055};
    imem[2] = r_op(5'd1, 5'd1, 5'd1, 6'b100001);
    imem[3] = i_op(6'b001000, 5'd0, 5'd1, 16'd55);
    imem[4] = i_op(OP_SW, 5'd0, 5'd1, 16'd0);
    do_reset();
    run(1);
    for (int k = 1; k <= 3; k++) begin
      chk("R8 pc at unknown word", imem_addr_o, 32'(4 * k));
      chk("R8 R9 no store on unknown", {31'd0, dmem_we_o}, 32'd0);
      run(1);
    end
    chk("R8 pc after unknowns", imem_addr_o, 32'd16);
    run(1);
    chk("R8 register untouched", dmem[0], 32'd9);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_mem();
    t_r0();
    t_branch();
    t_jump();
    t_illegal();
    summary();
  end

endmodule